// File: doc/BRIEF.md
# RTC BCD Seconds Register

This block is the seconds stage of a real-time clock. It keeps seconds as two BCD digits from 00 to 59 and advances them by one each time a one-second strobe arrives from the prescaler. When the count goes from 59 back to 00, it raises a one-cycle carry that drives the minutes stage.

A processor sees the block as one 8-bit register. A read returns the two digits in the low seven bits. The top bit is a busy flag that is high while an advance is in progress. Software should only trust a read when busy is low.

Software can load a new seconds value, but only under four conditions:
- the protect enable is set;
- no advance is in progress;
- the ones digit of the data is a valid BCD value;
- the tens digit of the data is a valid BCD value.

A synchronous hardware reset clears the register, and so does a separate soft-reset input from the clock controller.

Top module: `rtc_sec_reg`

## Requirements
- R1: While `rst` is high at a clock edge, the register clears. After that edge `rd_data` reads 0x00 and `carry_out` is 0.
- R2: While `soft_rst` is high at a clock edge, the register clears to 0x00 in the same way. This also cancels an advance that is in progress, so the register still reads 0x00 on the following cycle.
- R3: Bits 3:0 hold the ones digit in BCD and bits 6:4 hold the tens digit in BCD. On each advance the ones digit counts up from 0 to 9. Past 9 it goes back to 0 and the tens digit increments. The tens digit stays within 0 to 5, so the value always lies in 00..59.
- R4: An advance from 59 gives 00. `carry_out` is high for exactly one cycle, and that cycle is the first cycle in which 00 is visible.
- R5: Bit 7 of `rd_data` is the busy flag. It rises on the cycle after `tick` is sampled high and stays high for exactly 2 cycles. During those cycles the digits still show the old value. The new value appears in the same cycle that busy falls.
- R6: A `tick` sampled while busy is high is ignored. It does not lengthen the window and does not cause a second advance.
- R7: A write is accepted when all of the following hold at a clock edge: `wr_en` is 1, `prot_en` is 1, busy is 0, and the data is valid BCD (ones digit 9 or less, tens digit 5 or less). The written value is visible on the next cycle.
- R8: A write with `prot_en` at 0 is ignored.
- R9: A write made while busy is high is ignored. The advance in progress completes from the old value.
- R10: A write whose ones digit is above 9 or whose tens digit is above 5 is rejected, and the previous value is kept.
- R11: Bit 7 of `wr_data` has no effect. The busy flag stays 0 after a write with that bit set.
- R12: A `tick` sampled in the same cycle as an accepted write is dropped. No busy window starts, and the register holds the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst | input | 1 | Synchronous clear requested by the clock controller |
| tick | input | 1 | One-second strobe, one cycle wide |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data: bits 6:4 tens digit, bits 3:0 ones digit, bit 7 unused |
| prot_en | input | 1 | Write protect enable; writes are allowed only while it is 1 |
| rd_data | output | 8 | Bit 7 busy flag, bits 6:4 tens digit, bits 3:0 ones digit |
| carry_out | output | 1 | One-cycle carry pulse to the minutes stage on the 59-to-00 advance |

## Verification
The hardest conditions to reach are the collisions inside the two-cycle update window:
- a write landing while busy is high;
- a second strobe landing while busy is high;
- a soft reset cutting the window short;
- a strobe in the same cycle as an accepted write.

Each is reached by directed stimulus. The bench first raises `tick` on one falling edge. It then places the competing input on the following falling edges, counted against the known window length. It checks the register on every cycle of the window and on the cycle after it. The 59-to-00 carry is reached both by loading 59 directly and by a run of sixty strobes from 00. The run also checks that exactly one carry appears per minute.

// File: rtl/rtc_sec_pkg.sv
package rtc_sec_pkg;

    localparam int ONES_W    = 4;
    localparam int TENS_W    = 3;
    localparam int REG_W     = ONES_W + TENS_W + 1;
    localparam int ONES_LAST = 9;
    localparam int TENS_LAST = 5;
    localparam int BUSY_CYC  = 2;

    typedef struct packed {
        logic [TENS_W-1:0] tens;
        logic [ONES_W-1:0] ones;
    } bcd_sec_t;

    // True when both digits lie inside their legal BCD ranges
    function automatic logic bcd_ok(input bcd_sec_t v);
        return (v.ones <= ONES_W'(ONES_LAST)) && (v.tens <= TENS_W'(TENS_LAST));
    endfunction

    // True when the value is the last second of a minute
    function automatic logic bcd_at_end(input bcd_sec_t v);
        return (v.ones == ONES_W'(ONES_LAST)) && (v.tens == TENS_W'(TENS_LAST));
    endfunction

    // One-second advance with digit roll-over
    function automatic bcd_sec_t bcd_inc(input bcd_sec_t v);
        bcd_sec_t r;
        r = v;
        if (v.ones >= ONES_W'(ONES_LAST)) begin
            r.ones = '0;
            if (v.tens >= TENS_W'(TENS_LAST)) begin
                r.tens = '0;
            end else begin
                r.tens = v.tens + 1'b1;
            end
        end else begin
            r.ones = v.ones + 1'b1;
        end
        return r;
    endfunction

endpackage

// File: rtl/rtc_sec_busy.sv
module rtc_sec_busy
    import rtc_sec_pkg::*;
#(
    parameter int CYC = BUSY_CYC
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic start,
    output logic busy,
    output logic commit
);

    localparam int CW = $clog2(CYC + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= CW'(CYC);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign busy   = (cnt != '0);
    assign commit = (cnt == CW'(1));

endmodule

// File: rtl/rtc_sec_counter.sv
module rtc_sec_counter
    import rtc_sec_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     clr,
    input  logic     load,
    input  bcd_sec_t load_val,
    input  logic     step,
    output bcd_sec_t value,
    output logic     carry
);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            value <= '0;
            carry <= 1'b0;
        end else begin
            carry <= step && !load && bcd_at_end(value);
            if (load) begin
                value <= load_val;
            end else if (step) begin
                value <= bcd_inc(value);
            end
        end
    end

endmodule

// File: rtl/rtc_sec_wgate.sv
module rtc_sec_wgate
    import rtc_sec_pkg::*;
(
    input  logic             wr_en,
    input  logic             prot_en,
    input  logic             busy,
    input  logic [REG_W-1:0] wr_data,
    output logic             accept,
    output bcd_sec_t         wval
);

    // Bit REG_W-1 of the write data is dropped here
    assign wval   = bcd_sec_t'(wr_data[REG_W-2:0]);
    assign accept = wr_en && prot_en && !busy && bcd_ok(wval);

endmodule

// File: rtl/rtc_sec_reg.sv
module rtc_sec_reg
    import rtc_sec_pkg::*;
#(
    parameter int WIN = BUSY_CYC
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             soft_rst,
    input  logic             tick,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             prot_en,
    output logic [REG_W-1:0] rd_data,
    output logic             carry_out
);

    logic     busy;
    logic     commit;
    logic     accept;
    logic     start;
    bcd_sec_t wval;
    bcd_sec_t value;

    rtc_sec_wgate u_gate (
        .wr_en   (wr_en),
        .prot_en (prot_en),
        .busy    (busy),
        .wr_data (wr_data),
        .accept  (accept),
        .wval    (wval)
    );

    // An accepted write wins over a strobe in the same cycle
    assign start = tick && !busy && !accept;

    rtc_sec_busy #(.CYC(WIN)) u_busy (
        .clk    (clk),
        .rst    (rst),
        .clr    (soft_rst),
        .start  (start),
        .busy   (busy),
        .commit (commit)
    );

    rtc_sec_counter u_cnt (
        .clk      (clk),
        .rst      (rst),
        .clr      (soft_rst),
        .load     (accept),
        .load_val (wval),
        .step     (commit),
        .value    (value),
        .carry    (carry_out)
    );

    assign rd_data = {busy, value};

endmodule

// File: rtl/rtc_sec_reg_chk.sv
module rtc_sec_reg_chk
    import rtc_sec_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             soft_rst,
    input logic             tick,
    input logic             wr_en,
    input logic [REG_W-1:0] wr_data,
    input logic             prot_en,
    input logic [REG_W-1:0] rd_data,
    input logic             carry_out
);

    logic [1:0] age;

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            age <= '0;
        end else if (age != 2'd3) begin
            age <= age + 1'b1;
        end
    end

    AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (rst || soft_rst)
        (rd_data[3:0] <= 4'd9) && (rd_data[6:4] <= 3'd5)); // R3

    AST_CARRY_SINGLE: assert property (@(posedge clk) disable iff (rst || soft_rst || age < 2'd2)
        carry_out |=> !carry_out); // R4

    AST_CARRY_WRAP: assert property (@(posedge clk) disable iff (rst || soft_rst || age < 2'd2)
        carry_out |-> (rd_data[6:0] == 7'h00) && ($past(rd_data[6:0]) == 7'h59)); // R4

    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst || soft_rst || age < 2'd2)
        $rose(rd_data[7]) |=> rd_data[7]); // R5

    AST_BUSY_END: assert property (@(posedge clk) disable iff (rst || soft_rst || age < 2'd2)
        (rd_data[7] && $past(rd_data[7])) |=> !rd_data[7]); // R5

    AST_PROT_BLOCK: assert property (@(posedge clk) disable iff (rst || soft_rst || age < 2'd2)
        (wr_en && !prot_en && !rd_data[7] && !tick) |=> $stable(rd_data)); // R8

    AST_BAD_BCD: assert property (@(posedge clk) disable iff (rst || soft_rst || age < 2'd2)
        (wr_en && !rd_data[7] && !tick && ((wr_data[3:0] > 4'd9) || (wr_data[6:4] > 3'd5)))
        |=> $stable(rd_data)); // R10

endmodule

bind rtc_sec_reg rtc_sec_reg_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .soft_rst  (soft_rst),
    .tick      (tick),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .prot_en   (prot_en),
    .rd_data   (rd_data),
    .carry_out (carry_out)
);

// File: tb/rtc_sec_reg_test.sv
module rtc_sec_reg_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       soft_rst = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       prot_en = 1'b0;
    logic [7:0] rd_data;
    logic       carry_out;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    rtc_sec_reg uut (
        .clk       (clk),
        .rst       (rst),
        .soft_rst  (soft_rst),
        .tick      (tick),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .prot_en   (prot_en),
        .rd_data   (rd_data),
        .carry_out (carry_out)
    );

    // start value, value after one advance, expected carry
    localparam int NV = 8;
    localparam logic [16:0] VEC [NV] = '{
        {8'h00, 8'h01, 1'b0},
        {8'h08, 8'h09, 1'b0},
        {8'h09, 8'h10, 1'b0},
        {8'h19, 8'h20, 1'b0},
        {8'h45, 8'h46, 1'b0},
        {8'h39, 8'h40, 1'b0},
        {8'h58, 8'h59, 1'b0},
        {8'h59, 8'h00, 1'b1}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] d, input logic p);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d; prot_en = p;
        @(negedge clk);
        wr_en = 1'b0; prot_en = 1'b0;
    endtask

    // Leaves the bench one cycle after the strobe edge (busy expected high)
    task automatic do_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 rd_data", rd_data, 8'h00);
        chk("R1 carry", {7'd0, carry_out}, 8'h00);
        rst = 1'b0;

        // R3 R4 R5: table walk
        for (int i = 0; i < NV; i++) begin
            do_write(VEC[i][16:9], 1'b1);
            chk("R7 load", rd_data, VEC[i][16:9]);
            do_tick();
            chk("R5 busy cycle 1", rd_data, {1'b1, VEC[i][15:9]});
            @(negedge clk);
            chk("R5 busy cycle 2", rd_data, {1'b1, VEC[i][15:9]});
            @(negedge clk);
            chk("R3 advance", rd_data, VEC[i][8:1]);
            chk("R4 carry", {7'd0, carry_out}, {7'd0, VEC[i][0]});
            @(negedge clk);
            chk("R4 carry drop", {7'd0, carry_out}, 8'h00);
        end

        // R8: protect enable low
        do_write(8'h00, 1'b1);
        do_write(8'h12, 1'b0);
        chk("R8 protected", rd_data, 8'h00);

        // R10: bad BCD
        do_write(8'h33, 1'b1);
        do_write(8'h5A, 1'b1);
        chk("R10 ones>9", rd_data, 8'h33);
        do_write(8'h60, 1'b1);
        chk("R10 tens>5", rd_data, 8'h33);

        // R11: bit 7 ignored
        do_write(8'hA5, 1'b1);
        chk("R11 bit7", rd_data, 8'h25);

        // R9: write during busy
        do_write(8'h10, 1'b1);
        do_tick();
        wr_en = 1'b1; wr_data = 8'h40; prot_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; prot_en = 1'b0;
        chk("R9 busy write", rd_data, 8'h90);
        @(negedge clk);
        chk("R9 result", rd_data, 8'h11);

        // R6: strobe during busy
        do_write(8'h20, 1'b1);
        do_tick();
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        chk("R6 window", rd_data, 8'hA0);
        @(negedge clk);
        chk("R6 one advance", rd_data, 8'h21);
        @(negedge clk);
        chk("R6 no second window", rd_data, 8'h21);

        // R12: strobe with accepted write
        @(negedge clk);
        tick = 1'b1; wr_en = 1'b1; wr_data = 8'h37; prot_en = 1'b1;
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b0; prot_en = 1'b0;
        chk("R12 written", rd_data, 8'h37);
        @(negedge clk);
        chk("R12 no busy", rd_data, 8'h37);
        @(negedge clk);
        chk("R12 no advance", rd_data, 8'h37);

        // R2: soft reset during busy
        do_write(8'h42, 1'b1);
        do_tick();
        soft_rst = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0;
        chk("R2 cleared", rd_data, 8'h00);
        @(negedge clk);
        chk("R2 update cancelled", rd_data, 8'h00);

        // R3 R4: full minute
        begin
            int carries;
            carries = 0;
            for (int s = 0; s < 60; s++) begin
                do_tick();
                repeat (3) begin
                    @(negedge clk);
                    if (carry_out) carries++;
                end
            end
            chk("R3 full minute", rd_data, 8'h00);
            chk("R4 carries per minute", 8'(carries), 8'd1);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule